// File: doc/BRIEF.md
# Two-Deep Per-Channel Sample Buffer with Data-Ready Signalling

This block sits between the conversion engine of a six-channel ADC and its serial output stage. Every conversion-complete strobe delivers one word per channel, and each word is stored in a small per-channel queue that holds at most two samples. The serial side sees the oldest stored sample of every channel at once. One frame-read strobe removes one sample from every channel.

The block drives a per-channel ready status bit and an active-low data-ready pin. The status bit stays set while any sample of its channel is still stored, so a host that skipped a period must read two frames to clear it. In level format the pin shows whether anything is pending. It is released for one cycle after each frame read, so a read that leaves a second sample behind gives only a one-cycle high pulse. In pulse format the pin instead marks each new conversion with a one-cycle low pulse. A sync/clear pulse empties every queue so that the output lines up with the host again.

Top module: `sample_buffer_drdy`

## Requirements
- R1: During and after synchronous reset, `ch_ready` is all zeros, `head_words` is all zeros and `drdy_n` is 1.
- R2: A conversion strobe into an empty channel makes that channel's word appear on its slice of `head_words`, and sets its `ch_ready` bit, in the cycle after the strobe.
- R3: A channel holds at most two samples. A conversion into a full channel with no read discards the oldest sample, so the head becomes the previously newer sample.
- R4: With two samples held, one frame read leaves `ch_ready` set and presents the newer sample. A second read clears `ch_ready`.
- R5: When each conversion is followed by a read before the next conversion, `ch_ready` clears after every read.
- R6: A `sync_clear` pulse empties every channel. In the next cycle `ch_ready` is 0 and `drdy_n` is 1, and a conversion or read in the same cycle is discarded.
- R7: With `drdy_pulse_mode` = 0 (level format), `drdy_n` in the cycle after an edge is 0 when any sample is pending after that edge, and 1 when none is pending.
- R8: In level format, `drdy_n` is 1 for the one cycle after a frame read. It returns to 0 in the following cycle if samples remain.
- R9: A frame read and a conversion in the same cycle pop first and then push. A full channel stays full, with the older survivor at the head. A channel holding one sample then holds only the new word.
- R10: With `drdy_pulse_mode` = 1 (pulse format), `drdy_n` is 0 for exactly the one cycle after each conversion strobe that is not cleared by sync, and 1 otherwise.
- R11: A frame read on an empty channel has no effect. `ch_ready` stays 0, and the next conversion lands at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_strobe | input | 1 | One-cycle conversion-complete strobe |
| conv_words | input | NUM_CH*SAMPLE_W | Channel words for the strobe, channel 0 in the low bits |
| frame_read | input | 1 | One-cycle frame-read strobe; pops one sample per channel |
| sync_clear | input | 1 | One-cycle sync pulse; empties all channels |
| drdy_pulse_mode | input | 1 | 0 = level format, 1 = pulse format |
| head_words | output | NUM_CH*SAMPLE_W | Oldest stored sample of each channel |
| ch_ready | output | NUM_CH | Per-channel ready status, 1 while samples are stored |
| drdy_n | output | 1 | Active-low data-ready pin |

## Verification
A wrong occupancy count shows at the ports one cycle after the edge that corrupts it. A channel that holds too many samples keeps `ch_ready` set after the second read. A channel that drops a sample early clears it after the first read, or presents the wrong word at the head. A slot update in the wrong order shows on `head_words` in the cycle after a push into a full channel or a combined read and push. A fault in the pin logic appears either as a missing one-cycle release after a read or as a pin that stays low with nothing pending. The bench checks every output after every edge, across all length-four sequences of idle, push, read, combined and sync operations in both pin formats.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SLOTS = 2;
  typedef logic [1:0] occ_t;
  typedef enum logic {
    FMT_LEVEL = 1'b0,
    FMT_PULSE = 1'b1
  } drdy_fmt_e;
endpackage

// File: rtl/sbuf_chan_pair.sv
module sbuf_chan_pair
  import sbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic                pop,
  input  logic                clr,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] head,
  output logic                ready,
  output logic                pending_nxt
);
  localparam occ_t OCC_FULL = occ_t'(SLOTS);

  occ_t                cnt;
  occ_t                cnt_nxt;
  occ_t                after_pop;
  logic                do_pop;
  logic [SAMPLE_W-1:0] slot_old;
  logic [SAMPLE_W-1:0] slot_new;

  always_comb begin
    do_pop    = pop && (cnt != '0);
    after_pop = cnt - occ_t'(do_pop);
    if (clr)
      cnt_nxt = '0;
    else if (push)
      cnt_nxt = (after_pop == OCC_FULL) ? OCC_FULL : after_pop + occ_t'(1);
    else
      cnt_nxt = after_pop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      slot_old <= '0;
      slot_new <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (do_pop)
        slot_old <= slot_new;
      if (push) begin
        if (after_pop == OCC_FULL) begin
          slot_old <= slot_new;
          slot_new <= din;
        end else if (after_pop == '0) begin
          slot_old <= din;
        end else begin
          slot_new <= din;
        end
      end
    end
  end

  assign head        = slot_old;
  assign ready       = (cnt != '0);
  assign pending_nxt = (cnt_nxt != '0);

  assert_full_stays_full_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == OCC_FULL && push && !pop && !clr) |=> (ready && cnt == OCC_FULL));
  assert_one_left_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == OCC_FULL && pop && !push && !clr) |=> ready);
  assert_push_empty_head_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && push && !clr) |=> (head == $past(din)));
  assert_sync_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> !ready);
  assert_empty_read_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && pop && !push && !clr) |=> !ready);
endmodule

// File: rtl/sbuf_drdy_pin.sv
module sbuf_drdy_pin
  import sbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fmt,
  input  logic rd,
  input  logic conv,
  input  logic sync,
  input  logic any_pending_nxt,
  output logic drdy_n
);
  always_ff @(posedge clk) begin
    if (rst)
      drdy_n <= 1'b1;
    else if (sync)
      drdy_n <= 1'b1;
    else if (drdy_fmt_e'(fmt) == FMT_PULSE)
      drdy_n <= ~conv;
    else
      drdy_n <= rd | ~any_pending_nxt;
  end

  assert_release_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    (!fmt && rd) |=> drdy_n);
  assert_pulse_on_conv_R10: assert property (@(posedge clk) disable iff (rst)
    (fmt && conv && !sync) |=> !drdy_n);
  assert_level_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!fmt && !rd && !sync && !any_pending_nxt) |=> drdy_n);
endmodule

// File: rtl/sample_buffer_drdy.sv
module sample_buffer_drdy
  import sbuf_pkg::*;
#(
  parameter int unsigned NUM_CH   = 6,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       conv_strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] conv_words,
  input  logic                       frame_read,
  input  logic                       sync_clear,
  input  logic                       drdy_pulse_mode,
  output logic [NUM_CH*SAMPLE_W-1:0] head_words,
  output logic [NUM_CH-1:0]          ch_ready,
  output logic                       drdy_n
);
  logic [NUM_CH-1:0] pend_nxt;
  logic              any_pend_nxt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    sbuf_chan_pair #(.SAMPLE_W(SAMPLE_W)) i_chan (
      .clk         (clk),
      .rst         (rst),
      .push        (conv_strobe),
      .pop         (frame_read),
      .clr         (sync_clear),
      .din         (conv_words[g*SAMPLE_W +: SAMPLE_W]),
      .head        (head_words[g*SAMPLE_W +: SAMPLE_W]),
      .ready       (ch_ready[g]),
      .pending_nxt (pend_nxt[g])
    );
  end

  assign any_pend_nxt = |pend_nxt;

  sbuf_drdy_pin i_pin (
    .clk             (clk),
    .rst             (rst),
    .fmt             (drdy_pulse_mode),
    .rd              (frame_read),
    .conv            (conv_strobe),
    .sync            (sync_clear),
    .any_pending_nxt (any_pend_nxt),
    .drdy_n          (drdy_n)
  );

  assert_sync_pin_high_R6: assert property (@(posedge clk) disable iff (rst)
    sync_clear |=> (drdy_n && ch_ready == '0));
  assert_level_pending_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!drdy_pulse_mode && !frame_read && !sync_clear && conv_strobe) |=> !drdy_n);
  assert_steady_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_ready[0] && !$past(ch_ready[0]) && frame_read && !conv_strobe && !sync_clear)
      |=> (ch_ready == '0));
endmodule

// File: tb/test_sample_buffer_drdy.sv
module test_sample_buffer_drdy;
  localparam int NCH = 6;
  localparam int SW  = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              conv_strobe = 1'b0;
  logic [NCH*SW-1:0] conv_words = '0;
  logic              frame_read = 1'b0;
  logic              sync_clear = 1'b0;
  logic              drdy_pulse_mode = 1'b0;
  logic [NCH*SW-1:0] head_words;
  logic [NCH-1:0]    ch_ready;
  logic              drdy_n;

  int n_checks = 0;
  int n_fail   = 0;
  int seq      = 1;
  bit finished = 1'b0;

  int          m_cnt [NCH];
  logic [SW-1:0] m_old [NCH];
  logic [SW-1:0] m_new [NCH];
  logic        m_pin = 1'b1;

  always #10 clk = ~clk;

  sample_buffer_drdy #(.NUM_CH(NCH), .SAMPLE_W(SW)) i_sample_buffer_drdy (
    .clk(clk), .rst(rst), .conv_strobe(conv_strobe), .conv_words(conv_words),
    .frame_read(frame_read), .sync_clear(sync_clear),
    .drdy_pulse_mode(drdy_pulse_mode), .head_words(head_words),
    .ch_ready(ch_ready), .drdy_n(drdy_n));

  function automatic logic [SW-1:0] word(int s, int ch);
    return {s[15:0], ch[7:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      chk(ch_ready[ch] == (m_cnt[ch] != 0), tag, "ch_ready", ch_ready[ch], m_cnt[ch] != 0);
      if (m_cnt[ch] != 0)
        chk(head_words[ch*SW +: SW] == m_old[ch], tag, "head_words",
            head_words[ch*SW +: SW], m_old[ch]);
    end
    chk(drdy_n == m_pin, tag, "drdy_n", drdy_n, m_pin);
  endtask

  task automatic cyc(bit c, bit r, bit s, bit f, string tag);
    int after;
    @(negedge clk);
    conv_strobe     = c;
    frame_read      = r;
    sync_clear      = s;
    drdy_pulse_mode = f;
    for (int ch = 0; ch < NCH; ch++) conv_words[ch*SW +: SW] = word(seq, ch);
    after = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (s) m_cnt[ch] = 0;
      else begin
        if (r && m_cnt[ch] > 0) begin m_old[ch] = m_new[ch]; m_cnt[ch]--; end
        if (c) begin
          if (m_cnt[ch] == 2) begin m_old[ch] = m_new[ch]; m_new[ch] = word(seq, ch); end
          else if (m_cnt[ch] == 0) begin m_old[ch] = word(seq, ch); m_cnt[ch] = 1; end
          else begin m_new[ch] = word(seq, ch); m_cnt[ch] = 2; end
        end
      end
      after += m_cnt[ch];
    end
    if (s) m_pin = 1'b1;
    else if (f) m_pin = ~c;
    else m_pin = r | (after == 0);
    @(posedge clk);
    #2;
    seq++;
    compare(tag);
  endtask

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin m_cnt[ch] = 0; m_old[ch] = '0; m_new[ch] = '0; end
    repeat (3) @(posedge clk);
    #2;
    chk(drdy_n == 1'b1, "R1", "drdy_n in reset", drdy_n, 1);
    chk(ch_ready == '0, "R1", "ch_ready in reset", ch_ready, 0);
    chk(head_words == '0, "R1", "head_words in reset", head_words[31:0], 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    compare("R1");
    // R11: read on empty is ignored, then push lands at head
    cyc(0, 1, 0, 0, "R11");
    cyc(1, 0, 0, 0, "R11_R2");
    // R5: read every period
    cyc(0, 1, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R5");
    // R3: three pushes drop the oldest
    cyc(1, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, "R3");
    // R4 / R8: drain two entries, momentary release
    cyc(0, 1, 0, 0, "R4_R8");
    cyc(0, 0, 0, 0, "R8_R7");
    cyc(0, 1, 0, 0, "R4");
    cyc(0, 0, 0, 0, "R7");
    // R9: combined read and push on full and on single
    cyc(1, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, "R9");
    cyc(1, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, "R9");
    cyc(1, 1, 0, 0, "R9");
    // R6: sync with simultaneous push
    cyc(1, 0, 0, 0, "R6");
    cyc(1, 1, 1, 0, "R6");
    // R10: pulse format
    cyc(1, 0, 0, 1, "R10");
    cyc(0, 0, 0, 1, "R10");
    cyc(1, 1, 0, 1, "R10");
    cyc(0, 1, 0, 1, "R10");
    cyc(0, 0, 1, 1, "R10_R6");
    // sweep of all length-4 op sequences in both formats
    for (int f = 0; f < 2; f++) begin
      for (int code = 0; code < 625; code++) begin
        int k = code;
        for (int step = 0; step < 4; step++) begin
          int op = k % 5;
          k = k / 5;
          case (op)
            0: cyc(0, 0, 0, f[0], "R7_R10_sweep");
            1: cyc(1, 0, 0, f[0], "R2_R3_sweep");
            2: cyc(0, 1, 0, f[0], "R4_R8_sweep");
            3: cyc(1, 1, 0, f[0], "R9_sweep");
            default: cyc(0, 0, 1, f[0], "R6_sweep");
          endcase
        end
        cyc(0, 0, 1, f[0], "R6_sweep");
      end
    end
    @(negedge clk);
    conv_strobe = 0; frame_read = 0; sync_clear = 0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule